// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This controller lets several hardware thread contexts take turns on one single-issue pipeline. Each context keeps its own program counter, a ready flag and a register-file bank. The active thread keeps fetching until the pipeline reports a long-latency stall, such as a miss in the second-level cache. The controller then stops fetch and records the PC of the stalling instruction in that thread's context. It waits for the pipeline to report that it is empty, selects another ready thread, switches the register bank and holds fetch off for a fixed start-up window. After that window, fetch resumes from the new thread's saved PC.

A stalled thread drops out of the rotation until an external wake-up line for that thread is pulsed, for example when the miss data comes back. If no thread is ready after a drain, the controller parks with fetch off. It leaves that state as soon as any thread is woken.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After synchronous reset, thread 0 is active and fetch is enabled. The fetch PC is BOOT_BASE, thread t's PC is BOOT_BASE + t*BOOT_STEP, all ready flags are set, and the bank select is one-hot with bit t set for active thread t.
- R2: While running without a stall, the active thread's PC takes `next_pc_i` at each clock edge, and `fetch_pc_o` shows that value in the next cycle.
- R3: A stall sampled while running turns fetch off from the next cycle. Fetch stays off, and the active thread stays the same, until `pipe_empty_i` is sampled high.
- R4: At the edge where the drain completes, the chosen thread becomes active, the bank select follows it and `fetch_pc_o` shows its saved PC. Fetch then stays off for exactly REFILL_CYC cycles before it turns on.
- R5: The stalling thread's ready flag reads 0 from the cycle after the stall. A high `wake_i[t]` sets flag t at the next edge, and a wake wins over a clear in the same cycle.
- R6: `stall_i` has no effect while the controller is draining, refilling or idle. Ready flags and the active thread are unchanged by it.
- R7: The next thread is the first ready one in the order current+1, current+2, … modulo NTHR. The current thread comes last and is chosen only if it is ready.
- R8: The PC saved on a switch is `stall_pc_i`, and the thread resumes fetch from exactly that PC.
- R9: If no thread is ready when the drain completes, fetch stays off until a wake arrives. The woken thread then becomes active after a refill of REFILL_CYC cycles.
- R10: A thread that is not active keeps its PC unchanged across any number of switches of other threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Long-latency stall reported by the pipeline |
| stall_pc_i | input | PCW | PC of the instruction that stalled |
| next_pc_i | input | PCW | Next PC from the fetch stage |
| pipe_empty_i | input | 1 | No instruction left in flight |
| wake_i | input | NTHR | Per-thread wake-up pulses |
| act_tid_o | output | TIDW | Active thread number |
| fetch_pc_o | output | PCW | PC presented to fetch |
| fetch_en_o | output | 1 | Fetch enable |
| rf_bank_o | output | NTHR | One-hot register bank select |
| ready_o | output | NTHR | Per-thread ready flags |

## Verification
All outputs come from registers, so every result shows up one edge after the input that causes it. Fetch turns off in the cycle after the stall. The new thread, its bank and its PC appear in the cycle after `pipe_empty_i` is taken. Fetch turns back on REFILL_CYC+1 cycles after that input. The bench drives inputs on falling edges and reads outputs on the falling edge that counts those registers. A scoreboard queue holds the thread and PC expected when fetch next turns on. A monitor pops that entry on the rising fetch enable, so the switch target is checked whatever the path to it, including the wait in the idle state.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;

    // Switch controller states
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_REFILL = 2'd2,
        ST_IDLE   = 2'd3
    } sw_state_e;

    // Width helper for small counters and indices
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cgmt_rr_pick.sv
module cgmt_rr_pick #(
    parameter int NTHR = 4,
    parameter int TIDW = cgmt_pkg::idx_w(NTHR)
) (
    input  logic [NTHR-1:0] ready_i,
    input  logic [TIDW-1:0] base_i,
    output logic            found_o,
    output logic [TIDW-1:0] tid_o
);

    // Search base+1 .. base+NTHR (mod NTHR); base itself is tried last
    always_comb begin
        found_o = 1'b0;
        tid_o   = base_i;
        for (int k = 1; k <= NTHR; k++) begin
            int cand;
            cand = (int'(base_i) + k) % NTHR;
            if (!found_o && ready_i[cand]) begin
                found_o = 1'b1;
                tid_o   = TIDW'(cand);
            end
        end
    end

endmodule

// File: rtl/cgmt_ctx_bank.sv
module cgmt_ctx_bank #(
    parameter int             NTHR      = 4,
    parameter int             PCW       = 32,
    parameter int             TIDW      = cgmt_pkg::idx_w(NTHR),
    parameter logic [PCW-1:0] BOOT_BASE = 'h1000,
    parameter logic [PCW-1:0] BOOT_STEP = 'h100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TIDW-1:0] wr_tid_i,
    input  logic            wr_en_i,
    input  logic [PCW-1:0]  wr_pc_i,
    input  logic [NTHR-1:0] clr_i,
    input  logic [NTHR-1:0] wake_i,
    input  logic [TIDW-1:0] rd_tid_i,
    output logic [PCW-1:0]  rd_pc_o,
    output logic [NTHR-1:0] ready_o
);

    logic [PCW-1:0]  pc_q [NTHR];
    logic [NTHR-1:0] ready_q;

    // One PC register per context
    for (genvar t = 0; t < NTHR; t++) begin : g_ctx
        localparam logic [PCW-1:0] BOOT_PC = BOOT_BASE + PCW'(t) * BOOT_STEP;
        always_ff @(posedge clk) begin
            if (rst) begin
                pc_q[t] <= BOOT_PC;
            end else if (wr_en_i && (wr_tid_i == TIDW'(t))) begin
                pc_q[t] <= wr_pc_i;
            end
        end
    end

    // Wake has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= '1;
        end else begin
            ready_q <= (ready_q & ~clr_i) | wake_i;
        end
    end

    assign rd_pc_o = pc_q[rd_tid_i];
    assign ready_o = ready_q;

endmodule

// File: rtl/cgmt_sw_fsm.sv
module cgmt_sw_fsm #(
    parameter int NTHR       = 4,
    parameter int TIDW       = cgmt_pkg::idx_w(NTHR),
    parameter int REFILL_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stall_i,
    input  logic                pipe_empty_i,
    input  logic                pick_found_i,
    input  logic [TIDW-1:0]     pick_tid_i,
    output cgmt_pkg::sw_state_e state_o,
    output logic [TIDW-1:0]     act_o,
    output logic                fetch_en_o,
    output logic                save_stall_o
);
    import cgmt_pkg::*;

    localparam int CW = idx_w(REFILL_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(REFILL_CYC - 1);

    sw_state_e       state_q;
    logic [TIDW-1:0] act_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            act_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (stall_i) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (pipe_empty_i) begin
                        if (pick_found_i) begin
                            act_q   <= pick_tid_i;
                            cnt_q   <= CNT_LOAD;
                            state_q <= ST_REFILL;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (pick_found_i) begin
                        act_q   <= pick_tid_i;
                        cnt_q   <= CNT_LOAD;
                        state_q <= ST_REFILL;
                    end
                end
                ST_REFILL: begin
                    if (cnt_q == '0) state_q <= ST_RUN;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign state_o      = state_q;
    assign act_o        = act_q;
    assign fetch_en_o   = (state_q == ST_RUN);
    assign save_stall_o = (state_q == ST_RUN) && stall_i;

endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
    parameter int             NTHR       = 4,
    parameter int             PCW        = 32,
    parameter int             REFILL_CYC = 3,
    parameter logic [PCW-1:0] BOOT_BASE  = 'h1000,
    parameter logic [PCW-1:0] BOOT_STEP  = 'h100,
    parameter int             TIDW       = cgmt_pkg::idx_w(NTHR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic [PCW-1:0]  stall_pc_i,
    input  logic [PCW-1:0]  next_pc_i,
    input  logic            pipe_empty_i,
    input  logic [NTHR-1:0] wake_i,
    output logic [TIDW-1:0] act_tid_o,
    output logic [PCW-1:0]  fetch_pc_o,
    output logic            fetch_en_o,
    output logic [NTHR-1:0] rf_bank_o,
    output logic [NTHR-1:0] ready_o
);
    import cgmt_pkg::*;

    sw_state_e       sw_state;
    logic [TIDW-1:0] act_tid;
    logic            fetch_en;
    logic            save_stall;
    logic            pick_found;
    logic [TIDW-1:0] pick_tid;
    logic [NTHR-1:0] ready;
    logic [NTHR-1:0] clr_vec;
    logic [PCW-1:0]  wr_pc;

    cgmt_sw_fsm #(
        .NTHR(NTHR), .TIDW(TIDW), .REFILL_CYC(REFILL_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .stall_i(stall_i), .pipe_empty_i(pipe_empty_i),
        .pick_found_i(pick_found), .pick_tid_i(pick_tid),
        .state_o(sw_state), .act_o(act_tid),
        .fetch_en_o(fetch_en), .save_stall_o(save_stall)
    );

    cgmt_rr_pick #(.NTHR(NTHR), .TIDW(TIDW)) u_pick (
        .ready_i(ready), .base_i(act_tid),
        .found_o(pick_found), .tid_o(pick_tid)
    );

    // Stall PC replaces the fetch-stage next PC so the instruction replays
    assign wr_pc = save_stall ? stall_pc_i : next_pc_i;

    for (genvar t = 0; t < NTHR; t++) begin : g_dec
        assign clr_vec[t]   = save_stall && (act_tid == TIDW'(t));
        assign rf_bank_o[t] = (act_tid == TIDW'(t));
    end

    cgmt_ctx_bank #(
        .NTHR(NTHR), .PCW(PCW), .TIDW(TIDW),
        .BOOT_BASE(BOOT_BASE), .BOOT_STEP(BOOT_STEP)
    ) u_ctx (
        .clk(clk), .rst(rst),
        .wr_tid_i(act_tid), .wr_en_i(fetch_en), .wr_pc_i(wr_pc),
        .clr_i(clr_vec), .wake_i(wake_i),
        .rd_tid_i(act_tid), .rd_pc_o(fetch_pc_o), .ready_o(ready)
    );

    assign act_tid_o  = act_tid;
    assign fetch_en_o = fetch_en;
    assign ready_o    = ready;

endmodule

// File: rtl/cgmt_sw_chk.sv
module cgmt_sw_chk #(
    parameter int NTHR       = 4,
    parameter int PCW        = 32,
    parameter int REFILL_CYC = 3,
    parameter int TIDW       = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                stall_i,
    input logic [PCW-1:0]      next_pc_i,
    input logic                pipe_empty_i,
    input logic [NTHR-1:0]     wake_i,
    input logic [TIDW-1:0]     act_tid_o,
    input logic [PCW-1:0]      fetch_pc_o,
    input logic                fetch_en_o,
    input logic [NTHR-1:0]     rf_bank_o,
    input logic [NTHR-1:0]     ready_o,
    input cgmt_pkg::sw_state_e sw_state
);
    import cgmt_pkg::*;

    int unsigned refill_len_q;

    always_ff @(posedge clk) begin
        if (rst)                       refill_len_q <= 0;
        else if (sw_state == ST_REFILL) refill_len_q <= refill_len_q + 1;
        else                           refill_len_q <= 0;
    end

    // R1: exactly one bank selected
    p_bank_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(rf_bank_o) == 1);

    // R2: running PC follows the fetch stage
    p_pc_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_en_o && !stall_i) |=> (fetch_pc_o == $past(next_pc_i)));

    // R3: stall stops fetch next cycle
    p_stall_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (fetch_en_o && stall_i) |=> !fetch_en_o);

    // R3: undrained pipeline keeps fetch off and thread fixed
    p_drain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sw_state == ST_DRAIN && !pipe_empty_i) |=> (!fetch_en_o && $stable(act_tid_o)));

    // R4: refill lasts the configured number of cycles
    p_refill_len_r4: assert property (@(posedge clk) disable iff (rst)
        (sw_state == ST_RUN && refill_len_q != 0) |-> (refill_len_q == REFILL_CYC));

    // R5: stalled thread leaves the ready set unless woken
    p_ready_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch_en_o && stall_i && wake_i == '0) |=> !ready_o[$past(act_tid_o)]);

    // R6: stall outside running leaves ready flags alone
    p_stall_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (!fetch_en_o && stall_i) |=> (ready_o == ($past(ready_o) | $past(wake_i))));

endmodule

bind cgmt_switch_ctrl cgmt_sw_chk #(
    .NTHR(NTHR), .PCW(PCW), .REFILL_CYC(REFILL_CYC), .TIDW(TIDW)
) u_sw_chk (
    .clk(clk), .rst(rst), .stall_i(stall_i), .next_pc_i(next_pc_i),
    .pipe_empty_i(pipe_empty_i), .wake_i(wake_i), .act_tid_o(act_tid_o),
    .fetch_pc_o(fetch_pc_o), .fetch_en_o(fetch_en_o), .rf_bank_o(rf_bank_o),
    .ready_o(ready_o), .sw_state(sw_state)
);

// File: tb/cgmt_switch_ctrl_tb_top.sv
module cgmt_switch_ctrl_tb_top;

    localparam int NTHR = 4;
    localparam int PCW  = 32;
    localparam int RCYC = 3;
    localparam int TIDW = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            stall_i;
    logic [PCW-1:0]  stall_pc_i;
    logic [PCW-1:0]  next_pc_i;
    logic            pipe_empty_i;
    logic [NTHR-1:0] wake_i;
    logic [TIDW-1:0] act_tid_o;
    logic [PCW-1:0]  fetch_pc_o;
    logic            fetch_en_o;
    logic [NTHR-1:0] rf_bank_o;
    logic [NTHR-1:0] ready_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int             tid;
        logic [PCW-1:0] pc;
        string          req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    cgmt_switch_ctrl #(
        .NTHR(NTHR), .PCW(PCW), .REFILL_CYC(RCYC),
        .BOOT_BASE(32'h1000), .BOOT_STEP(32'h100)
    ) dut_i (
        .clk(clk), .rst(rst), .stall_i(stall_i), .stall_pc_i(stall_pc_i),
        .next_pc_i(next_pc_i), .pipe_empty_i(pipe_empty_i), .wake_i(wake_i),
        .act_tid_o(act_tid_o), .fetch_pc_o(fetch_pc_o), .fetch_en_o(fetch_en_o),
        .rf_bank_o(rf_bank_o), .ready_o(ready_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Monitor: on each rising fetch enable, pop the expected switch target
    logic prev_en = 1'b1;
    always @(negedge clk) begin
        if (!rst && fetch_en_o && !prev_en) begin
            if (sb_q.size() == 0) begin
                check("R4 unexpected fetch restart", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " tid"}, 32'(act_tid_o), 32'(e.tid));
                check({e.req, " pc"}, fetch_pc_o, e.pc);
                check("R4 bank", 32'(rf_bank_o), 32'(1 << e.tid));
            end
        end
        prev_en <= rst ? 1'b1 : fetch_en_o;
    end

    // Stall the active thread, drain for n cycles (with stray stalls), expect a target
    task automatic do_switch(input logic [PCW-1:0] spc, input logic [NTHR-1:0] wk,
                             input int exp_tid, input logic [PCW-1:0] exp_pc,
                             input int drain_n, input string req);
        int old;
        logic [NTHR-1:0] rdy_exp;
        old     = int'(act_tid_o);
        rdy_exp = (ready_o & ~(NTHR'(1) << old)) | wk;
        stall_i = 1'b1; stall_pc_i = spc; wake_i = wk;
        @(negedge clk);
        stall_i = 1'b0; wake_i = '0;
        check("R3 fetch off after stall", 32'(fetch_en_o), 32'd0);
        check("R5 ready after stall", 32'(ready_o), 32'(rdy_exp));
        for (int i = 0; i < drain_n; i++) begin
            stall_i = 1'b1; stall_pc_i = 32'hdead;   // R6 stray stall
            @(negedge clk);
            stall_i = 1'b0;
            check("R3 hold fetch off", 32'(fetch_en_o), 32'd0);
            check("R3 thread fixed", 32'(act_tid_o), 32'(old));
            check("R6 stall ignored", 32'(ready_o), 32'(rdy_exp));
        end
        sb_q.push_back('{exp_tid, exp_pc, req});
        pipe_empty_i = 1'b1;
        @(negedge clk);
        pipe_empty_i = 1'b0;
        check("R7 selected thread", 32'(act_tid_o), 32'(exp_tid));
        check("R4 pc at switch", fetch_pc_o, exp_pc);
        check("R4 refill fetch off", 32'(fetch_en_o), 32'd0);
        for (int i = 1; i < RCYC; i++) begin
            @(negedge clk);
            check("R4 refill fetch off", 32'(fetch_en_o), 32'd0);
        end
        @(negedge clk);
        check("R4 fetch on after refill", 32'(fetch_en_o), 32'd1);
    endtask

    initial begin
        rst = 1'b1; stall_i = 1'b0; stall_pc_i = '0; next_pc_i = 32'h1000;
        pipe_empty_i = 1'b0; wake_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 tid", 32'(act_tid_o), 32'd0);
        check("R1 fetch en", 32'(fetch_en_o), 32'd1);
        check("R1 pc", fetch_pc_o, 32'h1000);
        check("R1 bank", 32'(rf_bank_o), 32'd1);
        check("R1 ready", 32'(ready_o), 32'hf);
        // R2 running PC follows fetch stage
        next_pc_i = 32'h1004;
        @(negedge clk);
        check("R2 pc step", fetch_pc_o, 32'h1004);
        next_pc_i = 32'h1008;
        @(negedge clk);
        check("R2 pc step", fetch_pc_o, 32'h1008);
        // 0 -> 1 (R7, R10 boot pc kept)
        do_switch(32'h1008, '0, 1, 32'h1100, 2, "R7 first switch");
        next_pc_i = 32'h1104;
        @(negedge clk);
        check("R2 pc thread1", fetch_pc_o, 32'h1104);
        // 1 -> 2
        do_switch(32'h1104, '0, 2, 32'h1200, 1, "R10 thread2 boot pc");
        // R5 wake thread 0
        wake_i = 4'b0001;
        @(negedge clk);
        wake_i = '0;
        check("R5 wake sets flag", 32'(ready_o), 32'b1101);
        // 2 -> 3 (3 before 0 in circular order)
        do_switch(32'h1200, '0, 3, 32'h1300, 0, "R10 thread3 boot pc");
        // 3 -> 0 wraps, resumes at saved stall PC
        do_switch(32'h1300, '0, 0, 32'h1008, 1, "R8 resume saved pc");
        // 0 stalls with nobody ready: idle (R9)
        stall_i = 1'b1; stall_pc_i = 32'h1010;
        @(negedge clk);
        stall_i = 1'b0;
        pipe_empty_i = 1'b1;
        @(negedge clk);
        pipe_empty_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R9 idle fetch off", 32'(fetch_en_o), 32'd0);
        end
        check("R9 none ready", 32'(ready_o), 32'd0);
        sb_q.push_back('{2, 32'h1200, "R9 leave idle"});
        wake_i = 4'b0100;
        @(negedge clk);
        wake_i = '0;
        for (int i = 0; i < RCYC; i++) begin
            @(negedge clk);
            check("R9 refill from idle", 32'(fetch_en_o), 32'd0);
        end
        @(negedge clk);
        check("R9 fetch on", 32'(fetch_en_o), 32'd1);
        // Wake wins over clear; self chosen last (R5, R7)
        do_switch(32'h1240, 4'b0100, 2, 32'h1240, 1, "R7 self last");
        // Thread 0 kept its saved PC through everything (R10)
        wake_i = 4'b0001;
        @(negedge clk);
        wake_i = '0;
        do_switch(32'h1250, '0, 0, 32'h1010, 0, "R10 thread0 kept pc");
        repeat (2) @(negedge clk);
        check("R4 scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule